// File: doc/BRIEF.md
# Windowed Link Activity Meter

This block measures how long a link sits in a chosen condition, or how much payload it carries, across one measurement window. A single control register selects the item to measure and the window length, and it holds a start bit. A 64-bit result can be read as two 32-bit words at fixed offsets. Each cycle the block receives a set of condition flags, which cover link power states, recovery and every-cycle counting, together with one payload-unit count per traffic lane.

The window runs in one of two ways. In manual mode it stays open while software keeps the start bit at 1. In a timed mode a hardware timer closes it after a fixed number of cycles, which the block derives from a cycles-per-microsecond parameter. The result is cleared each time a new window opens. The two result words are read live and are not captured together, so a reader can see the high word change between its two accesses while a window is open.

The window controller has three states. In IDLE nothing counts. MANUAL is a window opened by software. TIMED is a window that hardware will close. The transitions are: ARM_MANUAL (IDLE to MANUAL, start rises with duration code 0), ARM_TIMED (IDLE to TIMED, start rises with a timed code), STOP (MANUAL or TIMED to IDLE, software writes start = 0) and EXPIRE (TIMED to IDLE, the timer reaches its last cycle).

Top module: `time_window_meter`

## Requirements
- R1: After reset the control register reads 0, both result words read 0 and no window is open.
- R2: The control register is at offset 0x10. The report code is in bits 31:24, the duration code in bits 15:8 and the start bit in bit 0. All other bits read as 0, and any address other than 0x10, 0x14 or 0x18 reads as 0.
- R3: For report codes 0x00 to 0x09, the result adds one per open-window cycle. Code 0x00 always adds. Code k (1 to 9) adds only when cond_in[k-1] is high in that cycle.
- R4: Report codes 0x20 to 0x23 add the payload-unit count of lane (code − 0x20) for each open-window cycle. Lane n is pay_units[n*PAY_W +: PAY_W].
- R5: Duration code 0x00 is manual mode. The window counts from the cycle after start rises until the cycle in which start = 0 is written. After that the result is held.
- R6: A timed duration code counts for exactly CYC_PER_US × T cycles. T is 1000 for code 0x01, 10000 for 0x02, 100000 for 0x03, 1000000 for 0x04, 2000000 for 0x05, 4000000 for 0x06 and 4 for 0xFF. When the window ends, the start bit clears itself and the result is held.
- R7: A 0-to-1 change of the start bit clears the result and opens a window. Writing 1 while the start bit is already 1 neither clears the result nor changes when the window ends.
- R8: The result low word is at offset 0x14 and the high word at 0x18. Both show the running count, so a carry into the high word can be seen while a window is open.
- R9: A duration code that is not listed in R6 and is not 0 sets the start bit and clears the result, but no counting takes place. A report code that is not listed in R3 or R4 adds nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational from rd_addr |
| cond_in | input | NCOND | Per-cycle condition flags for report codes 1 to 9 |
| pay_units | input | NLANE*PAY_W | Per-cycle payload-unit counts, one field per lane |

## Verification
The bench targets the window edges. A timed window must count exactly its cycle count. An off-by-one timer would give 7 or 9 instead of 8 for the shortest code, and 1999 or 2001 for the 1 ms code. A second start write during a window must leave both the count and the end cycle alone. A design that treated the write as a level would clear the result partway through. The bench also drives payload large enough to carry into the high word while a window is open. A design that captured the words together, or that truncated the adder, would show a stale or missing high word. Unused duration and report codes must hold the result at zero, so the bench would catch a decode that falls through to a default timer or to a default lane.

// File: rtl/tba_pkg.sv
package tba_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MANUAL,
        ST_TIMED
    } win_state_e;

    localparam logic [7:0] CTRL_OFS = 8'h10;
    localparam logic [7:0] LO_OFS   = 8'h14;
    localparam logic [7:0] HI_OFS   = 8'h18;

    localparam int TMR_W = 40;
    localparam int RES_W = 64;

    localparam logic [7:0] PAY_BASE = 8'h20;

    // Window length in cycles for a duration code; 0 means "not timed".
    function automatic logic [TMR_W-1:0] dur_cycles(input logic [7:0] code,
                                                    input longint unsigned cpu);
        longint unsigned us;
        case (code)
            8'h01:   us = 64'd1000;
            8'h02:   us = 64'd10000;
            8'h03:   us = 64'd100000;
            8'h04:   us = 64'd1000000;
            8'h05:   us = 64'd2000000;
            8'h06:   us = 64'd4000000;
            8'hFF:   us = 64'd4;
            default: us = 64'd0;
        endcase
        return TMR_W'(us * cpu);
    endfunction

endpackage

// File: rtl/tba_incr_sel.sv
module tba_incr_sel
    import tba_pkg::*;
#(
    parameter int NCOND = 9,
    parameter int NLANE = 4,
    parameter int PAY_W = 16
) (
    input  logic [7:0]             report,
    input  logic [NCOND-1:0]       cond,
    input  logic [NLANE*PAY_W-1:0] pay,
    output logic [PAY_W-1:0]       inc
);
    logic [PAY_W-1:0] lane_units [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_units[g] = pay[g*PAY_W +: PAY_W];
    end

    always_comb begin
        inc = '0;
        if (report == 8'h00) begin
            inc = PAY_W'(1);
        end
        for (int k = 1; k <= NCOND; k++) begin
            if (report == 8'(k)) begin
                inc = PAY_W'(cond[k-1]);
            end
        end
        for (int n = 0; n < NLANE; n++) begin
            if (report == PAY_BASE + 8'(n)) begin
                inc = lane_units[n];
            end
        end
    end
endmodule

// File: rtl/tba_window_fsm.sv
module tba_window_fsm
    import tba_pkg::*;
#(
    parameter int CYC_PER_US = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       arm,
    input  logic       disarm,
    input  logic [7:0] dur_code,
    output win_state_e state,
    output logic       expire
);
    win_state_e        state_d;
    logic [TMR_W-1:0]  rem_q;
    logic [TMR_W-1:0]  load;

    assign load = dur_cycles(dur_code, longint'(CYC_PER_US));

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (arm && dur_code == 8'h00)      state_d = ST_MANUAL;   // ARM_MANUAL
                else if (arm && load != '0)        state_d = ST_TIMED;    // ARM_TIMED
            end
            ST_MANUAL: begin
                if (disarm)                        state_d = ST_IDLE;     // STOP
            end
            ST_TIMED: begin
                if (disarm || rem_q == TMR_W'(1))  state_d = ST_IDLE;     // STOP / EXPIRE
            end
            default:                               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                         rem_q <= '0;
        else if (state == ST_IDLE && arm)   rem_q <= load;
        else if (state == ST_TIMED)         rem_q <= rem_q - TMR_W'(1);
    end

    assign expire = (state == ST_TIMED) && (rem_q == TMR_W'(1));

    // R6
    timer_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TIMED) |-> (rem_q != '0));
    // R6
    expire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (state == ST_IDLE));
endmodule

// File: rtl/tba_accum.sv
module tba_accum
    import tba_pkg::*;
#(
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [PAY_W-1:0] inc,
    output logic [RES_W-1:0] acc
);
    always_ff @(posedge clk) begin
        if (!rst_n)   acc <= '0;
        else if (clr) acc <= '0;
        else if (en)  acc <= acc + RES_W'(inc);
    end

    // R5
    hold_when_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(acc));
endmodule

// File: rtl/time_window_meter.sv
module time_window_meter
    import tba_pkg::*;
#(
    parameter int CYC_PER_US = 250,
    parameter int NCOND      = 9,
    parameter int NLANE      = 4,
    parameter int PAY_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [7:0]             wr_addr,
    input  logic [31:0]            wr_data,
    input  logic [7:0]             rd_addr,
    output logic [31:0]            rd_data,
    input  logic [NCOND-1:0]       cond_in,
    input  logic [NLANE*PAY_W-1:0] pay_units
);
    logic [7:0]       report_q;
    logic [7:0]       dur_q;
    logic             start_q;
    logic             wr_ctrl, arm, disarm, expire, counting;
    win_state_e       state;
    logic [PAY_W-1:0] inc;
    logic [RES_W-1:0] result;

    assign wr_ctrl = wr_en && (wr_addr == CTRL_OFS);
    assign arm     = wr_ctrl &&  wr_data[0] && !start_q;
    assign disarm  = wr_ctrl && !wr_data[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            report_q <= '0;
            dur_q    <= '0;
            start_q  <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                report_q <= wr_data[31:24];
                dur_q    <= wr_data[15:8];
            end
            if (arm)                  start_q <= 1'b1;
            else if (disarm || expire) start_q <= 1'b0;
        end
    end

    tba_window_fsm #(.CYC_PER_US(CYC_PER_US)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .disarm   (disarm),
        .dur_code (wr_data[15:8]),
        .state    (state),
        .expire   (expire)
    );

    tba_incr_sel #(.NCOND(NCOND), .NLANE(NLANE), .PAY_W(PAY_W)) i_sel (
        .report (report_q),
        .cond   (cond_in),
        .pay    (pay_units),
        .inc    (inc)
    );

    assign counting = (state != ST_IDLE);

    tba_accum #(.PAY_W(PAY_W)) i_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (arm),
        .en    (counting),
        .inc   (inc),
        .acc   (result)
    );

    always_comb begin
        unique case (rd_addr)
            CTRL_OFS: rd_data = {report_q, 8'h00, dur_q, 7'h00, start_q};
            LO_OFS:   rd_data = result[31:0];
            HI_OFS:   rd_data = result[63:32];
            default:  rd_data = '0;
        endcase
    end

    // R7
    fresh_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> (result == '0));
    // R5
    closed_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_q |-> (state == ST_IDLE));
    // R9
    unused_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_q && ((report_q > 8'h09 && report_q < 8'h20) || report_q > 8'h23))
        |=> $stable(result));
endmodule

// File: tb/test_time_window_meter.sv
`timescale 1ns/1ps
module test_time_window_meter;
    localparam int CPU   = 2;
    localparam int NCOND = 9;
    localparam int NLANE = 4;
    localparam int PAY_W = 32;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   wr_en = 1'b0;
    logic [7:0]             wr_addr = '0;
    logic [31:0]            wr_data = '0;
    logic [7:0]             rd_addr = '0;
    logic [31:0]            rd_data;
    logic [NCOND-1:0]       cond_in = '0;
    logic [NLANE*PAY_W-1:0] pay_units = '0;

    int  n_tests = 0, n_fail = 0;
    bit  rand_en = 1'b0;
    bit  done = 1'b0;

    // behavioural model state
    longint unsigned m_res = 0, m_rem = 0;
    int  m_rep = 0, m_dur = 0;
    bit  m_start = 0;
    int  m_mode = 0; // 0 closed, 1 manual, 2 timed

    time_window_meter #(.CYC_PER_US(CPU), .NCOND(NCOND), .NLANE(NLANE), .PAY_W(PAY_W))
    i_time_window_meter (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cond_in(cond_in), .pay_units(pay_units)
    );

    always #2 clk = ~clk;

    function automatic longint unsigned m_inc(int rep);
        if (rep == 0) return 1;
        if (rep >= 1 && rep <= NCOND) return longint'(cond_in[rep-1]);
        if (rep >= 32 && rep < 32 + NLANE) return longint'(pay_units[(rep-32)*PAY_W +: PAY_W]);
        return 0;
    endfunction

    function automatic longint unsigned m_len(int d);
        case (d)
            1: return 1000 * CPU;     2: return 10000 * CPU;
            3: return 100000 * CPU;   4: return 1000000 * CPU;
            5: return 2000000 * CPU;  6: return 4000000 * CPU;
            255: return 4 * CPU;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_res = 0; m_rem = 0; m_rep = 0; m_dur = 0; m_start = 0; m_mode = 0;
        end else begin
            if (m_mode != 0) m_res = m_res + m_inc(m_rep);
            if (m_mode == 2) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin m_mode = 0; m_start = 0; end
            end
            if (wr_en && wr_addr == 8'h10) begin
                m_rep = int'(wr_data[31:24]);
                m_dur = int'(wr_data[15:8]);
                if (wr_data[0] && !m_start) begin
                    m_start = 1; m_res = 0;
                    if (m_dur == 0) m_mode = 1;
                    else if (m_len(m_dur) != 0) begin m_mode = 2; m_rem = m_len(m_dur); end
                end else if (!wr_data[0]) begin
                    m_start = 0; m_mode = 0;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        case (a)
            8'h10: return {8'(m_rep), 8'h00, 8'(m_dur), 7'h00, m_start};
            8'h14: return m_res[31:0];
            8'h18: return m_res[63:32];
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model (R2, R8)
    always @(negedge clk) begin
        if (rst_n && !done) check("R8 per-cycle read", 64'(rd_data), 64'(m_read(rd_addr)));
    end

    always @(negedge clk) begin
        #1;
        if (rand_en) begin
            cond_in   = NCOND'($urandom);
            pay_units = {$urandom_range(0, 9), $urandom_range(0, 9), $urandom, $urandom_range(0, 50)};
        end
    end

    task automatic wr(logic [31:0] d, logic [7:0] a = 8'h10);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        rd_addr = a;
        #0.5 v = rd_data;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v, h1, h2;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(8'h10, v); check("R1 ctrl", v, 0);
        rd(8'h14, v); check("R1 lo", v, 0);
        rd(8'h18, v); check("R1 hi", v, 0);

        // R2 field layout, zero bits, stray address
        wr(32'h05AA_03FE);
        rd(8'h10, v); check("R2 fields", v, 32'h0500_0300);
        rd(8'h04, v); check("R2 other addr", v, 0);

        // R6 shortest timed window, every cycle: exactly 8
        wr(32'h0000_FF01);
        idle(20);
        rd(8'h14, v); check("R6 4us count", v, 8);
        rd(8'h10, v); check("R6 start self-clear", v & 1, 0);

        // R6 + R3 1 ms on condition code 3 held high: exactly 2000
        cond_in = 9'b000000100;
        wr(32'h0300_0101);
        idle(2100);
        rd(8'h14, v); check("R3 R6 1ms cond", v, 2000);
        cond_in = '0;

        // R4 lane 2 constant 3 units, 4 us: 24
        pay_units = '0; pay_units[2*PAY_W +: PAY_W] = 3;
        wr(32'h2200_FF01);
        idle(20);
        rd(8'h14, v); check("R4 lane2 payload", v, 24);
        pay_units = '0;

        // R7 restart write during timed window does not clear or extend
        wr(32'h0000_0101);
        idle(500);
        wr(32'h0000_0101);
        idle(1700);
        rd(8'h14, v); check("R7 rewrite no effect", v, 2000);

        // R3 random conditions, manual window (R5)
        rand_en = 1'b1;
        for (int c = 0; c < 10; c++) begin
            wr({8'(c), 24'h0000_01});
            idle(40);
            wr(32'h0);
            idle(5);
            rd(8'h14, v); check("R3 R5 manual cond", v, m_res[31:0]);
        end

        // R5 frozen after stop
        idle(30);
        rd(8'h14, v); check("R5 held after stop", v, m_res[31:0]);

        // R4 random payload, each lane
        for (int l = 0; l < NLANE; l++) begin
            wr({8'(32 + l), 24'h0000_01});
            idle(30);
            wr(32'h0);
            rd(8'h14, v); check("R4 lane lo", v, m_res[31:0]);
            rd(8'h18, v); check("R4 lane hi", v, m_res[63:32]);
        end

        // R7 restart while manual window is open: no clear
        wr(32'h0000_0001);
        idle(20);
        wr(32'h0000_0001);
        idle(5);
        rd(8'h14, v); check("R7 manual rewrite", v, m_res[31:0]);
        wr(32'h0);

        // R6 10 ms window, random conditions on code 1
        wr(32'h0100_0201);
        idle(20100);
        rd(8'h10, v); check("R6 10ms closed", v & 1, 0);
        rd(8'h14, v); check("R6 10ms count", v, m_res[31:0]);
        rand_en = 1'b0;
        cond_in = '0; pay_units = '0;

        // R9 unused duration code: start set, result cleared, no counting
        wr(32'h0000_0701);
        idle(20);
        rd(8'h10, v); check("R9 start set", v & 1, 1);
        rd(8'h14, v); check("R9 no count dur", v, 0);
        wr(32'h0);

        // R9 unused report code in manual window
        cond_in = '1; pay_units = '1;
        wr(32'h1500_0001);
        idle(20);
        rd(8'h14, v); check("R9 no count report", v, 0);
        wr(32'h0);
        cond_in = '0; pay_units = '0;

        // R8 carry into high word visible during window
        pay_units[0 +: PAY_W] = 32'hFFFF_FFFF;
        wr(32'h2000_0001);
        idle(2);
        rd(8'h18, h1);
        idle(3);
        rd(8'h18, h2);
        check("R8 high word live", 64'(h2 > h1), 1);
        wr(32'h0);
        rd(8'h18, v); check("R8 high stop", v, m_res[63:32]);
        pay_units = '0;

        idle(5);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule